// File: doc/BRIEF.md
# BCD Time-of-Day Calendar with Minute/Hour/Day Alarm

This block keeps wall-clock time for a chip that supplies a one-cycle pulse once per second. Seconds, minutes and hours are held as two-digit BCD values. Whole days are held as a 16-bit binary count. A carry out of seconds ripples through minutes, hours and day over the clock cycles that follow, one field per cycle. While that ripple is in progress a busy bit reads high and writes to the time fields are refused.

A separate alarm compares the live minute, hour and day against programmed values. Each of the three fields has its own compare enable. The comparison runs once at the end of every seconds rollover. A hit sets a sticky flag, which software clears by writing 1 to it. An interrupt line follows the flag when the interrupt enable is set.

All state sits in a byte-wide register space. The port has an address, write data, a write strobe and combinational read data.

Top module: `cal_rtc_core`

## Requirements
- R1: After reset every mapped register (0x14 to 0x1D) reads 0x00 and `alarm_irq` is low.
- R2: While the run bit (bit 0 of control register 0x14) is 1, each accepted `sec_tick` advances seconds (0x15) by one in BCD. 0x59 wraps to 0x00 and carries into minutes.
- R3: Minutes (0x16) count 0x00 to 0x59 in BCD and carry into hours on wrap. Hours (0x17) count 0x00 to 0x23 in BCD and carry into the day count on wrap.
- R4: The day count is a 16-bit binary number. Its low byte is at 0x18 and its high byte at 0x19. It increments once per hour wrap and wraps from 0xFFFF to 0x0000.
- R5: While the run bit is 0, ticks leave every time field unchanged.
- R6: Bit 7 of 0x14 (busy) reads 1 from the cycle after a tick that wraps seconds until the carry chain and the alarm check finish. That is two cycles for a minute-only carry and at most four cycles in all. A tick that does not wrap seconds never raises busy.
- R7: A write to 0x15 to 0x19 while busy is 1 is discarded. When busy is 0 the write is visible on the read port in the next cycle. If a write and a tick arrive in the same idle cycle, the write is applied and that tick is dropped.
- R8: The alarm registers are minute 0x1A, hour 0x1B, and day low/high 0x1C/0x1D. The compare enables are bit 3 (minute), bit 4 (hour) and bit 5 (day) of 0x14. When a seconds wrap has finished its carries, the alarm flag (bit 2 of 0x14) is set if at least one enable is 1 and every enabled field equals its alarm value. With no enable set, or on a tick that does not wrap seconds, the flag is not set.
- R9: The alarm flag stays set until software writes 0x14 with bit 2 = 1. Writing bit 2 = 0 leaves the flag as it is. Bits 0, 1, 3, 4 and 5 of 0x14 read back as written. Writes to bits 6 and 7 are ignored, and bit 6 reads 0.
- R10: `alarm_irq` is high exactly when the alarm flag and the interrupt enable (bit 1 of 0x14) are both 1.
- R11: Addresses outside 0x14 to 0x1D read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The bench walks every second, every minute value with a forced carry, and every hour value with a forced day carry. The expected BCD results are computed arithmetically. A counter that wrapped at the wrong BCD limit, such as 0x60 or 0x24, or that skipped the tens digit, shows up in these sweeps. The day is checked across its byte boundary and across its 0xFFFF wrap, where a design carrying only eight bits or saturating would return a wrong count. The busy window is sampled cycle by cycle while a seconds write is aimed into it. A design that let that write land, or that held busy for the wrong length, reports a wrong seconds value or a wrong busy bit. The alarm is driven with matching fields but no enable, with a one-day mismatch, and on a tick with no rollover. A design that fired in any of these cases sets the flag when it should not. The flag is also shown to survive a write of 0 and to clear on a write of 1.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int BYTE_W   = 8;
    localparam int DAY_W    = 16;
    localparam int TOD_N    = 3;

    localparam logic [BYTE_W-1:0] A_CTRL    = 8'h14;
    localparam logic [BYTE_W-1:0] A_SEC     = 8'h15;
    localparam logic [BYTE_W-1:0] A_MIN     = 8'h16;
    localparam logic [BYTE_W-1:0] A_HOUR    = 8'h17;
    localparam logic [BYTE_W-1:0] A_DAY_LO  = 8'h18;
    localparam logic [BYTE_W-1:0] A_DAY_HI  = 8'h19;
    localparam logic [BYTE_W-1:0] A_AMIN    = 8'h1A;
    localparam logic [BYTE_W-1:0] A_AHOUR   = 8'h1B;
    localparam logic [BYTE_W-1:0] A_ADAY_LO = 8'h1C;
    localparam logic [BYTE_W-1:0] A_ADAY_HI = 8'h1D;

    localparam logic [BYTE_W-1:0] SEC_MIN_LIMIT = 8'h59;
    localparam logic [BYTE_W-1:0] HOUR_LIMIT    = 8'h23;

    localparam int B_RUN   = 0;
    localparam int B_IE    = 1;
    localparam int B_FLAG  = 2;
    localparam int B_MEN   = 3;
    localparam int B_HEN   = 4;
    localparam int B_DEN   = 5;
    localparam int B_BUSY  = 7;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MIN   = 3'd1,
        ST_HOUR  = 3'd2,
        ST_DAY   = 3'd3,
        ST_CHECK = 3'd4
    } stage_e;

    typedef struct packed {
        stage_e                         stage;
        logic [TOD_N-1:0][BYTE_W-1:0]   tod;     // 0 sec, 1 min, 2 hour
        logic [DAY_W-1:0]               day;
        logic [BYTE_W-1:0]              amin;
        logic [BYTE_W-1:0]              ahour;
        logic [DAY_W-1:0]               aday;
        logic                           run;
        logic                           ie;
        logic                           flag;
        logic [2:0]                     cmp_en;  // 0 min, 1 hour, 2 day
    } cal_state_t;
endpackage

// File: rtl/cal_bcd_incr.sv
module cal_bcd_incr #(
    parameter int          W     = 8,
    parameter logic [W-1:0] LIMIT = 8'h59
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o,
    output logic         wrap_o
);
    localparam int NIB = W / 2;

    logic [NIB-1:0] ones, tens;

    always_comb begin
        ones   = val_i[NIB-1:0];
        tens   = val_i[W-1:NIB];
        wrap_o = 1'b0;
        if (val_i == LIMIT) begin
            val_o  = '0;
            wrap_o = 1'b1;
        end else if (ones == NIB'(9)) begin
            val_o = {tens + NIB'(1), {NIB{1'b0}}};
        end else begin
            val_o = {tens, ones + NIB'(1)};
        end
    end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
    parameter int BW = 8,
    parameter int DW = 16
) (
    input  logic [2:0]    en_i,
    input  logic [BW-1:0] cur_min_i,
    input  logic [BW-1:0] cur_hour_i,
    input  logic [DW-1:0] cur_day_i,
    input  logic [BW-1:0] al_min_i,
    input  logic [BW-1:0] al_hour_i,
    input  logic [DW-1:0] al_day_i,
    output logic          hit_o
);
    logic [2:0] field_ok;

    always_comb begin
        field_ok[0] = !en_i[0] || (cur_min_i  == al_min_i);
        field_ok[1] = !en_i[1] || (cur_hour_i == al_hour_i);
        field_ok[2] = !en_i[2] || (cur_day_i  == al_day_i);
        hit_o       = (|en_i) && (&field_ok);
    end
endmodule

// File: rtl/cal_rtc_core.sv
module cal_rtc_core
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [BYTE_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              alarm_irq
);
    cal_state_t st_q, st_d;

    logic [TOD_N-1:0][BYTE_W-1:0] inc_val;
    logic [TOD_N-1:0]             inc_wrap;
    logic                         alarm_hit;
    logic                         busy;
    logic                         time_addr;
    logic                         time_wr;

    genvar gi;
    generate
        for (gi = 0; gi < TOD_N; gi++) begin : g_field
            localparam logic [BYTE_W-1:0] LIM = (gi == TOD_N - 1) ? HOUR_LIMIT : SEC_MIN_LIMIT;
            cal_bcd_incr #(.W(BYTE_W), .LIMIT(LIM)) u_inc (
                .val_i  (st_q.tod[gi]),
                .val_o  (inc_val[gi]),
                .wrap_o (inc_wrap[gi])
            );
        end
    endgenerate

    cal_alarm_match #(.BW(BYTE_W), .DW(DAY_W)) u_match (
        .en_i       (st_q.cmp_en),
        .cur_min_i  (st_q.tod[1]),
        .cur_hour_i (st_q.tod[2]),
        .cur_day_i  (st_q.day),
        .al_min_i   (st_q.amin),
        .al_hour_i  (st_q.ahour),
        .al_day_i   (st_q.aday),
        .hit_o      (alarm_hit)
    );

    assign busy      = (st_q.stage != ST_IDLE);
    assign time_addr = (reg_addr >= A_SEC) && (reg_addr <= A_DAY_HI);
    assign time_wr   = reg_we && time_addr;

    always_comb begin
        st_d = st_q;

        unique case (st_q.stage)
            ST_IDLE: begin
                if (sec_tick && st_q.run && !time_wr) begin
                    st_d.tod[0] = inc_val[0];
                    if (inc_wrap[0]) st_d.stage = ST_MIN;
                end
            end
            ST_MIN: begin
                st_d.tod[1] = inc_val[1];
                st_d.stage  = inc_wrap[1] ? ST_HOUR : ST_CHECK;
            end
            ST_HOUR: begin
                st_d.tod[2] = inc_val[2];
                st_d.stage  = inc_wrap[2] ? ST_DAY : ST_CHECK;
            end
            ST_DAY: begin
                st_d.day   = st_q.day + DAY_W'(1);
                st_d.stage = ST_CHECK;
            end
            ST_CHECK: begin
                st_d.stage = ST_IDLE;
            end
            default: st_d.stage = ST_IDLE;
        endcase

        if (reg_we) begin
            case (reg_addr)
                A_CTRL: begin
                    st_d.run       = reg_wdata[B_RUN];
                    st_d.ie        = reg_wdata[B_IE];
                    st_d.cmp_en[0] = reg_wdata[B_MEN];
                    st_d.cmp_en[1] = reg_wdata[B_HEN];
                    st_d.cmp_en[2] = reg_wdata[B_DEN];
                    if (reg_wdata[B_FLAG]) st_d.flag = 1'b0;
                end
                A_SEC:     if (!busy) st_d.tod[0]   = reg_wdata;
                A_MIN:     if (!busy) st_d.tod[1]   = reg_wdata;
                A_HOUR:    if (!busy) st_d.tod[2]   = reg_wdata;
                A_DAY_LO:  if (!busy) st_d.day[7:0]  = reg_wdata;
                A_DAY_HI:  if (!busy) st_d.day[15:8] = reg_wdata;
                A_AMIN:    st_d.amin        = reg_wdata;
                A_AHOUR:   st_d.ahour       = reg_wdata;
                A_ADAY_LO: st_d.aday[7:0]   = reg_wdata;
                A_ADAY_HI: st_d.aday[15:8]  = reg_wdata;
                default: ;
            endcase
        end

        // a hit in the check cycle wins over a clear written in the same cycle
        if (st_q.stage == ST_CHECK && alarm_hit) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:    reg_rdata = {busy, 1'b0, st_q.cmp_en[2], st_q.cmp_en[1],
                                    st_q.cmp_en[0], st_q.flag, st_q.ie, st_q.run};
            A_SEC:     reg_rdata = st_q.tod[0];
            A_MIN:     reg_rdata = st_q.tod[1];
            A_HOUR:    reg_rdata = st_q.tod[2];
            A_DAY_LO:  reg_rdata = st_q.day[7:0];
            A_DAY_HI:  reg_rdata = st_q.day[15:8];
            A_AMIN:    reg_rdata = st_q.amin;
            A_AHOUR:   reg_rdata = st_q.ahour;
            A_ADAY_LO: reg_rdata = st_q.aday[7:0];
            A_ADAY_HI: reg_rdata = st_q.aday[15:8];
            default:   reg_rdata = '0;
        endcase
    end

    assign alarm_irq = st_q.flag & st_q.ie;

    p_stopped_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !reg_we && st_q.stage == ST_IDLE) |=> ($stable(st_q.tod) && $stable(st_q.day)));

    p_roll_starts_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage == ST_IDLE && sec_tick && st_q.run && !reg_we && st_q.tod[0] == 8'h59)
        |=> (st_q.stage == ST_MIN && st_q.tod[0] == 8'h00));

    p_check_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage == ST_CHECK) |=> (st_q.stage == ST_IDLE));

    p_sec_frozen_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage != ST_IDLE) |=> $stable(st_q.tod[0]));

    p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage == ST_DAY && st_q.day == 16'hFFFF) |=> (st_q.day == 16'h0000));

    p_flag_from_check_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> ($past(st_q.stage) == ST_CHECK));
endmodule

// File: tb/cal_rtc_core_test.sv
`timescale 1ns/1ps
module cal_rtc_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       alarm_irq;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    cal_rtc_core uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_day(output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(8'h18, lo);
        rd(8'h19, hi);
        d = {hi, lo};
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m,
                            input logic [7:0] s, input logic [15:0] d);
        wr(8'h17, h); wr(8'h16, m); wr(8'h15, s);
        wr(8'h18, d[7:0]); wr(8'h19, d[15:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] dv;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 8'h14; a <= 8'h1D; a++) begin
            rd(8'(a), v);
            chk("R1 reset value", {8'h0, v}, 16'h0000);
        end
        chk("R1 irq after reset", {15'h0, alarm_irq}, 16'h0000);

        // R11: unmapped addresses
        rd(8'h13, v); chk("R11 unmapped read", {8'h0, v}, 16'h0);
        wr(8'h20, 8'hFF);
        rd(8'h20, v); chk("R11 unmapped read after write", {8'h0, v}, 16'h0);
        rd(8'h14, v); chk("R11 ctrl untouched", {8'h0, v}, 16'h0);

        // R9: bits 7 and 6 ignore writes
        wr(8'h14, 8'hC0);
        rd(8'h14, v); chk("R9 ctrl bits 7:6 ignored", {8'h0, v}, 16'h0);

        // R5: stopped counter ignores ticks
        tick();
        rd(8'h15, v); chk("R5 stopped seconds", {8'h0, v}, 16'h0);

        // R2: full seconds sweep
        wr(8'h14, 8'h01);
        for (int s = 0; s < 60; s++) begin
            tick();
            rd(8'h15, v);
            chk("R2 seconds sweep", {8'h0, v}, {8'h0, bcd((s + 1) % 60)});
        end
        rd(8'h16, v); chk("R2 seconds carry into minutes", {8'h0, v}, 16'h0001);

        // R3: minute sweep with forced carry
        for (int m = 0; m < 60; m++) begin
            set_time(8'h00, bcd(m), 8'h59, 16'h0000);
            tick();
            rd(8'h16, v); chk("R3 minute sweep", {8'h0, v}, {8'h0, bcd((m + 1) % 60)});
            rd(8'h17, v); chk("R3 minute carry to hour", {8'h0, v}, (m == 59) ? 16'h1 : 16'h0);
            rd(8'h15, v); chk("R2 seconds wrapped", {8'h0, v}, 16'h0);
        end

        // R3/R4: hour sweep with forced day carry
        for (int h = 0; h < 24; h++) begin
            set_time(bcd(h), 8'h59, 8'h59, 16'h1234);
            tick();
            rd(8'h17, v); chk("R3 hour sweep", {8'h0, v}, {8'h0, bcd((h + 1) % 24)});
            rd_day(dv);   chk("R4 day after hour", dv, (h == 23) ? 16'h1235 : 16'h1234);
        end

        // R4: byte carry and full wrap
        set_time(8'h23, 8'h59, 8'h59, 16'h00FF);
        tick();
        rd_day(dv); chk("R4 day byte carry", dv, 16'h0100);
        set_time(8'h23, 8'h59, 8'h59, 16'hFFFF);
        tick();
        rd_day(dv); chk("R4 day wrap", dv, 16'h0000);
        rd(8'h17, v); chk("R4 hour after wrap", {8'h0, v}, 16'h0);

        // R7: idle write visible next cycle
        wr(8'h15, 8'h42);
        rd(8'h15, v); chk("R7 idle write lands", {8'h0, v}, 16'h42);

        // R6: no busy on a non-rolling tick
        wr(8'h15, 8'h10);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        rd(8'h14, v); chk("R6 no busy without roll", {15'h0, v[7]}, 16'h0);
        rd(8'h15, v); chk("R2 plain increment", {8'h0, v}, 16'h11);
        repeat (4) @(negedge clk);

        // R6/R7: busy window and discarded write
        set_time(8'h00, 8'h10, 8'h59, 16'h0000);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        rd(8'h14, v); chk("R6 busy first cycle", {8'h0, v}, 16'h81);
        reg_we = 1'b1; reg_addr = 8'h15; reg_wdata = 8'h33;
        @(negedge clk);
        reg_we = 1'b0;
        rd(8'h14, v); chk("R6 busy second cycle", {15'h0, v[7]}, 16'h1);
        @(negedge clk);
        rd(8'h14, v); chk("R6 busy cleared", {15'h0, v[7]}, 16'h0);
        rd(8'h15, v); chk("R7 busy write discarded", {8'h0, v}, 16'h00);
        rd(8'h16, v); chk("R3 minute after busy", {8'h0, v}, 16'h11);

        // R8: matching fields but no enable
        wr(8'h1A, 8'h05); wr(8'h1B, 8'h07); wr(8'h1C, 8'h00); wr(8'h1D, 8'h00);
        wr(8'h14, 8'h03);
        set_time(8'h07, 8'h04, 8'h59, 16'h0000);
        tick();
        rd(8'h14, v); chk("R8 no enable no flag", {8'h0, v}, 16'h03);

        // R8: minute enabled, tick without rollover
        wr(8'h14, 8'h0B);
        set_time(8'h07, 8'h05, 8'h10, 16'h0000);
        tick();
        rd(8'h14, v); chk("R8 no flag without roll", {8'h0, v}, 16'h0B);

        // R8/R10: minute hit
        set_time(8'h07, 8'h04, 8'h59, 16'h0000);
        tick();
        rd(8'h14, v); chk("R8 minute alarm flag", {8'h0, v}, 16'h0F);
        chk("R10 irq with flag and enable", {15'h0, alarm_irq}, 16'h1);

        // R9: write 0 keeps, R10: irq follows enable, write 1 clears
        wr(8'h14, 8'h0B);
        rd(8'h14, v); chk("R9 flag survives write 0", {8'h0, v}, 16'h0F);
        wr(8'h14, 8'h09);
        rd(8'h14, v); chk("R9 ctrl readback", {8'h0, v}, 16'h0D);
        chk("R10 irq off without enable", {15'h0, alarm_irq}, 16'h0);
        wr(8'h14, 8'h0F);
        rd(8'h14, v); chk("R9 flag cleared by write 1", {8'h0, v}, 16'h0B);
        chk("R10 irq off after clear", {15'h0, alarm_irq}, 16'h0);

        // R8: day+hour+minute hit across a day carry
        wr(8'h1A, 8'h00); wr(8'h1B, 8'h00); wr(8'h1C, 8'h01); wr(8'h1D, 8'h01);
        wr(8'h14, 8'h3B);
        set_time(8'h23, 8'h59, 8'h59, 16'h0100);
        tick();
        rd(8'h14, v); chk("R8 full alarm flag", {8'h0, v}, 16'h3F);
        chk("R10 irq full alarm", {15'h0, alarm_irq}, 16'h1);

        // R8: day mismatch
        wr(8'h14, 8'h3F);
        wr(8'h1C, 8'h02);
        set_time(8'h23, 8'h59, 8'h59, 16'h0100);
        tick();
        rd(8'h14, v); chk("R8 day mismatch no flag", {8'h0, v}, 16'h3B);

        // R8: alarm registers read back
        rd(8'h1C, v); chk("R8 alarm day low readback", {8'h0, v}, 16'h02);
        rd(8'h1D, v); chk("R8 alarm day high readback", {8'h0, v}, 16'h01);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule